// File: doc/BRIEF.md
# Biphase-Mark Stereo Subframe Transmitter

This block turns a stream of stereo 16-bit PCM sample pairs into a single biphase-mark coded serial line. It is clocked by the system clock and advanced by a cell-rate clock enable. One enable pulse equals one line cell, and there are two cells per data bit. Each stereo frame lasts 128 cells and carries a left subframe followed by a right subframe. Each subframe is 32 bit slots long.

Every subframe opens with a four-slot preamble. The preamble breaks the coding rule so that a receiver can find the subframe. It is chosen by channel and by a block counter that runs over 192 frames. The preamble is followed by auxiliary bits, audio padding, the sample, and four flag slots. One auxiliary bit is set so that the subframe parity stays even. This holds the parity slot at a fixed value when the block is not muted.

A new pair is taken through a valid/ready handshake only at the frame boundary. The pair is held for the whole of the next frame. A frame for which no pair was offered is still sent, with its correct preambles and zero data. Asserting mute marks the samples invalid without stopping the line.

Top module: `bmc_stereo_tx`

## Requirements
- R1: Every data slot (slots 4 to 31 of a subframe) takes two cells. The first cell always inverts the line level. The second cell inverts it again only when the bit is 1.
- R2: Within a subframe, slots 0-3 hold the preamble and aux bit k sits in slot 4+k. Slots 8-11 are zero padding, and sample bit k (least significant first) sits in slot 12+k. Validity sits in slot 28, user in 29, channel status in 30 and parity in 31. The left subframe occupies frame cells 0-63 and the right subframe occupies cells 64-127.
- R3: Preamble cells are sent in this time order. The block-start preamble is 1,1,1,0,1,0,0,0. The ordinary left preamble is 1,1,1,0,0,0,1,0. The right preamble is 1,1,1,0,0,1,0,0. These are the cells sent when the line is low before the preamble; when it is high, every preamble cell is inverted. The line is low at the start of every subframe.
- R4: The left subframe uses the block-start preamble in the first frame after reset and in every 192nd frame after that. Every other frame uses the ordinary left preamble.
- R5: When a sample is present, aux bit 0 equals the XOR of the 16 sample bits. The other aux bits, the padding, the user bit and the channel-status bit are 0. Slots 4-31 always hold an even number of ones.
- R6: Mute is sampled at each frame boundary and applies to the whole next frame. When it is set, the validity slot and the parity slot are both 1. When it is clear, both are 0.
- R7: When no pair was accepted at a frame boundary, both subframes of the next frame carry zero aux bits and zero sample bits. They keep the correct preambles, and their validity and parity slots follow R6.
- R8: pair_ready is high only in a clock cycle where cell_en is high on the last cell of a frame (cell 127). The pair is accepted when pair_valid is also high, and it is held unchanged for the whole following frame, whatever the inputs do.
- R9: After reset, line_out is 0, pair_ready is 0, and the first frame begins at cell 0 with no sample and mute clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_en | input | 1 | One pulse per line cell (two per data bit) |
| mute | input | 1 | Marks the samples of the next frame invalid |
| pair_valid | input | 1 | A sample pair is offered |
| pair_left | input | 16 | Left channel sample |
| pair_right | input | 16 | Right channel sample |
| pair_ready | output | 1 | Pair accepted at this edge if valid |
| line_out | output | 1 | Biphase-mark coded serial line |

## Verification
On every cycle, the assertions check the following: the bit-start and mid-bit transitions of the coder, even parity of each built subframe, a low line at each subframe start, the wrap of the 192-frame counter, and the holding register staying stable inside a frame. Only the bench's frame-by-frame comparisons can show the complete cell sequences. These include the choice and placement of each preamble, the sample placement, the effect of mute and of a missing pair, and the return of the block-start preamble after 192 frames.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int CELLS_PER_SLOT  = 2;
  localparam int SLOTS_PER_SUB   = 32;
  localparam int SUBS_PER_FRAME  = 2;
  localparam int CELLS_PER_SUB   = CELLS_PER_SLOT * SLOTS_PER_SUB;
  localparam int CELLS_PER_FRAME = CELLS_PER_SUB * SUBS_PER_FRAME;
  localparam int CELL_W          = $clog2(CELLS_PER_FRAME);
  localparam int SUB_CELL_W      = $clog2(CELLS_PER_SUB);
  localparam int SLOT_W          = $clog2(SLOTS_PER_SUB);
  localparam int PRE_SLOTS       = 4;
  localparam int PRE_CELLS       = PRE_SLOTS * CELLS_PER_SLOT;
  localparam int AUX_LO          = PRE_SLOTS;
  localparam int AUX_W           = 4;
  localparam int AUDIO_FIELD_W   = 20;
  localparam int SLOT_VALID      = 28;
  localparam int SLOT_USER       = 29;
  localparam int SLOT_CHSTAT     = 30;
  localparam int SLOT_PARITY     = 31;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_kind_e;

  // Cell k of the preamble (time order) is bit k of the result,
  // given for a low line level ahead of the preamble.
  function automatic logic [PRE_CELLS-1:0] pre_cells(input pre_kind_e kind);
    logic [PRE_CELLS-1:0] p;
    p = '0;
    p[0] = 1'b1;
    p[1] = 1'b1;
    p[2] = 1'b1;
    case (kind)
      PRE_BLOCK: p[4] = 1'b1;
      PRE_LEFT:  p[6] = 1'b1;
      default:   p[5] = 1'b1;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bmc_frame_seq.sv
module bmc_frame_seq
  import bmc_pkg::*;
#(
  parameter int SAMPLE_W         = 16,
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cell_en,
  input  logic                mute,
  input  logic                pair_valid,
  input  logic [SAMPLE_W-1:0] pair_left,
  input  logic [SAMPLE_W-1:0] pair_right,
  output logic                pair_ready,
  output logic [CELL_W-1:0]   cell_idx,
  output logic                block_start,
  output logic                have_pair,
  output logic                mute_held,
  output logic [SAMPLE_W-1:0] left_held,
  output logic [SAMPLE_W-1:0] right_held
);
  localparam int FCNT_W = $clog2(FRAMES_PER_BLOCK);
  localparam logic [CELL_W-1:0] LAST_CELL  = CELL_W'(CELLS_PER_FRAME - 1);
  localparam logic [FCNT_W-1:0] LAST_FRAME = FCNT_W'(FRAMES_PER_BLOCK - 1);

  logic [CELL_W-1:0]   cell_q, cell_d;
  logic [FCNT_W-1:0]   fcnt_q, fcnt_d;
  logic                have_q, have_d;
  logic                mute_q, mute_d;
  logic [SAMPLE_W-1:0] left_q, left_d;
  logic [SAMPLE_W-1:0] right_q, right_d;
  logic                frame_end;

  assign frame_end  = cell_en && (cell_q == LAST_CELL);
  assign pair_ready = frame_end;

  always_comb begin
    cell_d  = cell_q;
    fcnt_d  = fcnt_q;
    have_d  = have_q;
    mute_d  = mute_q;
    left_d  = left_q;
    right_d = right_q;
    if (cell_en) begin
      cell_d = frame_end ? '0 : cell_q + 1'b1;
    end
    if (frame_end) begin
      fcnt_d = (fcnt_q == LAST_FRAME) ? '0 : fcnt_q + 1'b1;
      have_d = pair_valid;
      mute_d = mute;
      if (pair_valid) begin
        left_d  = pair_left;
        right_d = pair_right;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q  <= '0;
      fcnt_q  <= '0;
      have_q  <= 1'b0;
      mute_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      cell_q  <= cell_d;
      fcnt_q  <= fcnt_d;
      have_q  <= have_d;
      mute_q  <= mute_d;
      left_q  <= left_d;
      right_q <= right_d;
    end
  end

  assign cell_idx    = cell_q;
  assign block_start = (fcnt_q == '0);
  assign have_pair   = have_q;
  assign mute_held   = mute_q;
  assign left_held   = left_q;
  assign right_held  = right_q;

  // R4: block counter stays in range and wraps to zero after the last frame
  p_fcnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= LAST_FRAME);
  p_block_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && fcnt_q == LAST_FRAME) |=> (fcnt_q == '0));
  // R8: held pair does not move except at a frame end
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(left_q) && $stable(right_q) && $stable(have_q)));
endmodule

// File: rtl/bmc_subframe_build.sv
module bmc_subframe_build
  import bmc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                     is_right,
  input  logic                     block_start,
  input  logic                     have_pair,
  input  logic                     mute_held,
  input  logic [SAMPLE_W-1:0]      left_held,
  input  logic [SAMPLE_W-1:0]      right_held,
  output logic [SLOTS_PER_SUB-1:0] word,
  output logic [PRE_CELLS-1:0]     pre
);
  localparam int PAD_W     = AUDIO_FIELD_W - SAMPLE_W;
  localparam int SAMPLE_LO = AUX_LO + AUX_W + PAD_W;

  logic [SAMPLE_W-1:0] sample;
  pre_kind_e           kind;

  assign sample = is_right ? right_held : left_held;

  always_comb begin
    word = '0;
    if (have_pair) begin
      word[AUX_LO]                    = ^sample;
      word[SAMPLE_LO +: SAMPLE_W]     = sample;
    end
    word[SLOT_USER]   = 1'b0;
    word[SLOT_CHSTAT] = 1'b0;
    word[SLOT_VALID]  = mute_held;
    word[SLOT_PARITY] = mute_held;
  end

  always_comb begin
    if (is_right)         kind = PRE_RIGHT;
    else if (block_start) kind = PRE_BLOCK;
    else                  kind = PRE_LEFT;
  end

  assign pre = pre_cells(kind);
endmodule

// File: rtl/bmc_line_coder.sv
module bmc_line_coder
  import bmc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cell_en,
  input  logic [CELL_W-1:0]        cell_idx,
  input  logic [SLOTS_PER_SUB-1:0] word,
  input  logic [PRE_CELLS-1:0]     pre,
  output logic                     line_out
);
  logic [SUB_CELL_W-1:0] sub_cell;
  logic [SLOT_W-1:0]     slot;
  logic                  half;
  logic                  in_pre;
  logic                  cur_bit;
  logic                  pol;
  logic                  line_q, line_d;
  logic                  pol_q, pol_d;

  assign sub_cell = cell_idx[SUB_CELL_W-1:0];
  assign slot     = sub_cell[SUB_CELL_W-1:1];
  assign half     = sub_cell[0];
  assign in_pre   = (slot < SLOT_W'(PRE_SLOTS));
  assign cur_bit  = word[slot];
  assign pol      = (sub_cell == '0) ? line_q : pol_q;

  always_comb begin
    line_d = line_q;
    pol_d  = pol_q;
    if (cell_en) begin
      if (in_pre)     line_d = pre[sub_cell[$clog2(PRE_CELLS)-1:0]] ^ pol;
      else if (!half) line_d = ~line_q;
      else            line_d = cur_bit ? ~line_q : line_q;
      if (sub_cell == '0) pol_d = line_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      pol_q  <= pol_d;
    end
  end

  assign line_out = line_q;

  // R1: every data bit starts with a transition
  p_bit_start_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && !in_pre && !half) |=> (line_q != $past(line_q)));
  // R1: mid-bit transition present exactly for a one
  p_mid_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && !in_pre && half) |=> ((line_q != $past(line_q)) == $past(cur_bit)));
  // R3: line is low whenever a subframe begins
  p_sub_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && sub_cell == '0) |-> !line_q);
  // R5: data and flag slots of each subframe carry even parity
  p_even_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && sub_cell == '0) |-> !(^word[SLOTS_PER_SUB-1:AUX_LO]));
endmodule

// File: rtl/bmc_stereo_tx.sv
module bmc_stereo_tx
  import bmc_pkg::*;
#(
  parameter int SAMPLE_W         = 16,
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cell_en,
  input  logic                mute,
  input  logic                pair_valid,
  input  logic [SAMPLE_W-1:0] pair_left,
  input  logic [SAMPLE_W-1:0] pair_right,
  output logic                pair_ready,
  output logic                line_out
);
  logic [CELL_W-1:0]        cell_idx;
  logic                     block_start;
  logic                     have_pair;
  logic                     mute_held;
  logic [SAMPLE_W-1:0]      left_held;
  logic [SAMPLE_W-1:0]      right_held;
  logic [SLOTS_PER_SUB-1:0] word;
  logic [PRE_CELLS-1:0]     pre;

  bmc_frame_seq #(
    .SAMPLE_W         (SAMPLE_W),
    .FRAMES_PER_BLOCK (FRAMES_PER_BLOCK)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cell_en     (cell_en),
    .mute        (mute),
    .pair_valid  (pair_valid),
    .pair_left   (pair_left),
    .pair_right  (pair_right),
    .pair_ready  (pair_ready),
    .cell_idx    (cell_idx),
    .block_start (block_start),
    .have_pair   (have_pair),
    .mute_held   (mute_held),
    .left_held   (left_held),
    .right_held  (right_held)
  );

  bmc_subframe_build #(
    .SAMPLE_W (SAMPLE_W)
  ) u_build (
    .is_right    (cell_idx[CELL_W-1]),
    .block_start (block_start),
    .have_pair   (have_pair),
    .mute_held   (mute_held),
    .left_held   (left_held),
    .right_held  (right_held),
    .word        (word),
    .pre         (pre)
  );

  bmc_line_coder u_coder (
    .clk      (clk),
    .rst_n    (rst_n),
    .cell_en  (cell_en),
    .cell_idx (cell_idx),
    .word     (word),
    .pre      (pre),
    .line_out (line_out)
  );
endmodule

// File: tb/tb_bmc_stereo_tx.sv
module tb_bmc_stereo_tx;
  logic        clk;
  logic        rst_n;
  logic        cell_en;
  logic        mute;
  logic        pair_valid;
  logic [15:0] pair_left;
  logic [15:0] pair_right;
  logic        pair_ready;
  logic        line_out;

  int checks;
  int errors;
  bit done;

  bmc_stereo_tx dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_en    (cell_en),
    .mute       (mute),
    .pair_valid (pair_valid),
    .pair_left  (pair_left),
    .pair_right (pair_right),
    .pair_ready (pair_ready),
    .line_out   (line_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // expected state, built from the requirements
  logic        e_lvl;
  int          e_fidx;
  logic        e_have, e_mute;
  logic [15:0] e_left, e_right;

  function automatic logic [31:0] make_word(input logic have, input logic [15:0] s,
                                            input logic m);
    logic [31:0] w;
    w = 32'h0;
    if (have) begin
      w[4] = ^s;
      for (int k = 0; k < 16; k++) w[12 + k] = s[k];
    end
    w[28] = m;
    w[31] = m;
    return w;
  endfunction

  // pat written in time order, leftmost cell first
  task automatic expect_sub(input logic [7:0] pat, input logic [31:0] w,
                            inout logic lvl, output logic [63:0] cells);
    logic base;
    base = lvl;
    for (int k = 0; k < 8; k++) cells[k] = pat[7 - k] ^ base;
    lvl = cells[7];
    for (int s = 4; s < 32; s++) begin
      cells[2*s]     = ~lvl;
      cells[2*s + 1] = w[s] ? lvl : ~lvl;
      lvl = cells[2*s + 1];
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s frame %0d got %h exp %h", tag, e_fidx, got, exp);
    end
  endtask

  task automatic one_cell(output logic c, output logic rdy);
    cell_en = 1'b1;
    #1 rdy = pair_ready;
    @(negedge clk);
    c = line_out;
    cell_en = 1'b0;
    @(negedge clk);
  endtask

  // runs one frame; offers the pair for the following frame
  task automatic run_frame(input logic offer, input logic [15:0] l, input logic [15:0] r,
                           input logic m);
    logic [127:0] got;
    logic [63:0]  exp_l, exp_r;
    logic         c, rdy, rdy_bad, rdy_last;
    string        tag;
    pair_valid = offer;
    pair_left  = l;
    pair_right = r;
    mute       = m;
    rdy_bad    = 1'b0;
    rdy_last   = 1'b0;
    for (int i = 0; i < 128; i++) begin
      one_cell(c, rdy);
      got[i] = c;
      if (i == 127) rdy_last = rdy;
      else if (rdy) rdy_bad = 1'b1;
    end
    // scramble inputs after acceptance: held copy must not follow (R8)
    pair_left  = ~l;
    pair_right = ~r;
    pair_valid = 1'b0;
    expect_sub((e_fidx == 0) ? 8'b11101000 : 8'b11100010,
               make_word(e_have, e_left, e_mute), e_lvl, exp_l);
    expect_sub(8'b11100100, make_word(e_have, e_right, e_mute), e_lvl, exp_r);
    if (!e_have)          tag = "R7 no-pair";
    else if (e_mute)      tag = "R6 mute";
    else if (e_fidx == 0) tag = "R4 block-start";
    else                  tag = "R1 R2 R3 R5 data";
    check(got[63:0] == exp_l, {tag, " left R8"}, got[63:0], exp_l);
    check(got[127:64] == exp_r, {tag, " right R8"}, got[127:64], exp_r);
    check(rdy_last && !rdy_bad, "R8 ready timing", {62'd0, rdy_bad, rdy_last},
          64'd1);
    e_have  = offer;
    e_mute  = m;
    if (offer) begin
      e_left  = l;
      e_right = r;
    end
    e_fidx = (e_fidx + 1) % 192;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog got hang exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; cell_en = 1'b0; mute = 1'b0; pair_valid = 1'b0;
    pair_left = 16'h0; pair_right = 16'h0;
    e_lvl = 1'b0; e_fidx = 0; e_have = 1'b0; e_mute = 1'b0;
    e_left = 16'h0; e_right = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(line_out == 1'b0 && pair_ready == 1'b0, "R9 reset", {62'd0, line_out, pair_ready},
          64'd0);
    @(negedge clk);
    run_frame(1'b1, 16'h0000, 16'hFFFF, 1'b0);
    run_frame(1'b1, 16'h8001, 16'h7FFE, 1'b0);
    run_frame(1'b1, 16'hA5A5, 16'h5A5A, 1'b0);
    run_frame(1'b1, 16'h0001, 16'h8000, 1'b1);
    run_frame(1'b1, 16'h1234, 16'hFEDC, 1'b1);
    run_frame(1'b0, 16'hDEAD, 16'hBEEF, 1'b0);
    run_frame(1'b0, 16'hDEAD, 16'hBEEF, 1'b1);
    run_frame(1'b1, 16'h0F0F, 16'hF0F0, 1'b0);
    lf = 16'hACE1;
    for (int f = 0; f < 190; f++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_frame(f % 37 != 5, lf, ~{lf[7:0], lf[15:8]}, f % 29 == 3);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule